// File: doc/BRIEF.md
# I2C Register Target with Access Windows

This block is an I2C target that gives a two-wire host access to a bank of byte-wide control registers and a small set of status bytes. It answers a 7-bit device address of the form `1101A11`, where `A` is taken from a strap input, so two identical targets can share one bus. A host writes by sending the device address with the write bit, a subaddress, and then any number of data bytes. It reads by setting the subaddress in the same way, then issuing a repeated start and the device address with the read bit, and clocking out bytes.

Control registers live in a write window, 00h to 21h by default, and appear in parallel on a flat output bus for the rest of the chip. Status bytes come in on a parallel input and can be read at 28h and at 2Ah to 2Ch. One byte pointer serves both directions and advances after every data byte, so a burst simply runs on across window edges. The block is clocked by the system clock. It oversamples the bus through two-stage synchronizers and pulls SDA low through an open-drain enable.

Top module: `i2c_regbank_target`

## Requirements
- R1: The target acknowledges a device byte whose upper seven bits are `1,1,0,1,addr_sel,1,1` (MSB first). Bit 0 is the direction: 0 for write, 1 for read. The acknowledge is SDA held low during the ninth SCL pulse.
- R2: A device byte with any other address is not acknowledged. The target then leaves SDA released and ignores every later byte until the next start condition.
- R3: In a write transfer, the byte after the device byte loads the pointer. Each later byte is acknowledged and stored into the control register that the pointer selects.
- R4: A data byte whose pointer falls outside 00h..21h is still acknowledged, but it changes no control register.
- R5: The pointer advances by one after every data byte, written or read. A burst that starts at 20h therefore writes 20h and 21h and then goes on to 22h.
- R6: A read returns bytes MSB first, starting at the pointer. 28h returns `stat_in[7:0]`, 2Ah returns `stat_in[15:8]`, 2Bh returns `stat_in[23:16]` and 2Ch returns `stat_in[31:24]`. A repeated start keeps the pointer.
- R7: A read at any address other than the four status addresses returns 00h. This includes the control registers.
- R8: When the host does not acknowledge a read byte, the target releases SDA and sends nothing more until the next start.
- R9: A start or stop condition in the middle of a byte aborts that byte. A byte cut short in this way is never written. After a start the target expects a device byte.
- R10: After reset every control register holds its byte of the `RST_IMAGE` parameter. With the default image, register 01h is 40h, 12h is 0Fh, 21h is 88h and all others are 00h.
- R11: The target changes its SDA drive only while SCL is low. The only exception is releasing it on a start or stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples SCL and SDA |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_sel | input | 1 | Strap value for the selectable device address bit |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| stat_in | input | 32 | Status bytes, byte 0 at 28h, bytes 1..3 at 2Ah..2Ch |
| ctrl_out | output | 272 | Control registers, register n at bits 8n+7..8n |

## Verification
A wrong bit counter or state in the byte engine shows up at SDA within one byte time. The acknowledge slot either moves, goes missing or appears on a foreign address, and read data comes out shifted by a bit. A corrupt pointer shows up on the next data byte: the wrong slice of `ctrl_out` changes, or a read returns another status byte or 00h. A window decoder that is off by one only shows up at the edges, so the bench writes the last writable register and the first one past it, and reads across the gap at 29h. A missed start or stop leaves a partial byte that lands in a register, which the aborted-transfer cases reveal as soon as the bus goes idle.

// File: rtl/i2crb_pkg.sv
// Package i2crb_pkg
// Shared types and default constants for the I2C register target.
// Assumes the default write window 00h..21h, so the default reset
// image is 34 bytes wide.
package i2crb_pkg;

    // Byte engine states
    typedef enum logic [2:0] {
        ENG_IDLE,   // not addressed, waiting for a start
        ENG_RX,     // shifting in a byte from the host
        ENG_ACK,    // driving our acknowledge slot
        ENG_TX,     // shifting out a read byte
        ENG_TXACK   // waiting for the host acknowledge
    } eng_state_t;

    // Meaning of the byte currently being received
    typedef enum logic [1:0] {
        RX_DEV,
        RX_SUB,
        RX_DATA
    } rx_kind_t;

    localparam int unsigned DEF_WR_LO   = 'h00;
    localparam int unsigned DEF_WR_HI   = 'h21;
    localparam int unsigned DEF_RD_SOLO = 'h28;
    localparam int unsigned DEF_RD_LO   = 'h2A;
    localparam int unsigned DEF_RD_HI   = 'h2C;

    // Default reset image: reg 01h = 40h, reg 12h = 0Fh, reg 21h = 88h
    localparam logic [271:0] DEF_RST_IMAGE =
        (272'h40 << (8 * 'h01)) |
        (272'h0F << (8 * 'h12)) |
        (272'h88 << (8 * 'h21));

endpackage

// File: rtl/i2crb_line_sync.sv
// Module i2crb_line_sync
// Brings SCL and SDA into the clock domain through a chain of flops.
// Then it flags SCL edges and start/stop conditions, one cycle each.
// Assumes the system clock is several times faster than SCL.
module i2crb_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_pin,
    input  logic sda_pin,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    // Synchronizer chains plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_pin};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_pin};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_lvl   = scl_pipe[STAGES-1];
    assign sda_lvl   = sda_pipe[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    // SDA moving while SCL stays high marks a bus condition
    assign bus_start = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign bus_stop  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2crb_byte_engine.sv
// Module i2crb_byte_engine
// Bit- and byte-level protocol engine. It matches the device address,
// loads the pointer, issues write strobes, serves read bytes and keeps
// the shared pointer that advances on every data byte.
// Assumes the edge and condition flags from i2crb_line_sync.
// SDA changes are made one cycle after a detected SCL fall.
module i2crb_byte_engine
    import i2crb_pkg::*;
#(
    parameter logic [3:0] DEV_HEAD = 4'b1101,
    parameter logic [1:0] DEV_TAIL = 2'b11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_sel,
    input  logic       scl_lvl,
    input  logic       sda_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_addr,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       sda_oe
);
    eng_state_t st;
    rx_kind_t   kind;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic [7:0] txsh;
    logic [7:0] ptr;
    logic       rw_read;
    logic       m_ack;
    logic       dev_match;

    // Compare the received device byte with the strapped address
    assign dev_match = (shreg[7:4] == DEV_HEAD) && (shreg[3] == addr_sel) &&
                       (shreg[2:1] == DEV_TAIL);
    assign rd_addr   = ptr;

    // Protocol state machine, shift registers and pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ENG_IDLE;
            kind    <= RX_DEV;
            bitcnt  <= 4'd0;
            shreg   <= 8'd0;
            txsh    <= 8'd0;
            ptr     <= 8'd0;
            rw_read <= 1'b0;
            m_ack   <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= 8'd0;
            wr_data <= 8'd0;
        end else begin
            wr_en <= 1'b0;
            if (bus_start) begin
                st     <= ENG_RX;
                kind   <= RX_DEV;
                bitcnt <= 4'd0;
                sda_oe <= 1'b0;
            end else if (bus_stop) begin
                st     <= ENG_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ENG_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_lvl};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            case (kind)
                                RX_DEV: begin
                                    if (dev_match) begin
                                        sda_oe  <= 1'b1;
                                        rw_read <= shreg[0];
                                        st      <= ENG_ACK;
                                    end else begin
                                        st <= ENG_IDLE;
                                    end
                                end
                                RX_SUB: begin
                                    ptr    <= shreg;
                                    sda_oe <= 1'b1;
                                    st     <= ENG_ACK;
                                end
                                default: begin
                                    wr_en   <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= shreg;
                                    ptr     <= ptr + 8'd1;
                                    sda_oe  <= 1'b1;
                                    st      <= ENG_ACK;
                                end
                            endcase
                        end
                    end
                    ENG_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= 4'd0;
                            if (kind == RX_DEV && rw_read) begin
                                txsh   <= {rd_data[6:0], 1'b0};
                                sda_oe <= ~rd_data[7];
                                ptr    <= ptr + 8'd1;
                                st     <= ENG_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                kind   <= (kind == RX_DEV) ? RX_SUB : RX_DATA;
                                st     <= ENG_RX;
                            end
                        end
                    end
                    ENG_TX: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                st     <= ENG_TXACK;
                            end else begin
                                sda_oe <= ~txsh[7];
                                txsh   <= {txsh[6:0], 1'b0};
                            end
                        end
                    end
                    ENG_TXACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (m_ack) begin
                                txsh   <= {rd_data[6:0], 1'b0};
                                sda_oe <= ~rd_data[7];
                                ptr    <= ptr + 8'd1;
                                bitcnt <= 4'd0;
                                st     <= ENG_TX;
                            end else begin
                                st <= ENG_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) ((sda_oe != $past(sda_oe)) && !$past(bus_start) && !$past(bus_stop)) |-> !scl_lvl); // R11
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) (st == ENG_IDLE) |-> !sda_oe); // R2
    AST_PTR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> (ptr == wr_addr + 8'd1)); // R5

endmodule

// File: rtl/i2crb_reg_file.sv
// Module i2crb_reg_file
// Control registers inside the write window, plus the read decoder for
// the status bytes. Writes outside the window are dropped here.
// Assumes the read addresses are one lone address followed by one
// contiguous range, and that all windows fit in 8-bit addresses.
module i2crb_reg_file #(
    parameter int unsigned WR_LO   = 'h00,
    parameter int unsigned WR_HI   = 'h21,
    parameter int unsigned RD_SOLO = 'h28,
    parameter int unsigned RD_LO   = 'h2A,
    parameter int unsigned RD_HI   = 'h2C,
    parameter logic [8*(WR_HI-WR_LO+1)-1:0] RST_IMAGE = '0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [7:0]                        wr_addr,
    input  logic [7:0]                        wr_data,
    input  logic [7:0]                        rd_addr,
    output logic [7:0]                        rd_data,
    input  logic [8*(RD_HI-RD_LO+2)-1:0]      stat_in,
    output logic [8*(WR_HI-WR_LO+1)-1:0]      ctrl_out
);
    localparam int unsigned NUM_WR  = WR_HI - WR_LO + 1;
    localparam int unsigned NUM_RNG = RD_HI - RD_LO + 1;

    logic wr_hit;

    // Window membership of the write address, with wrap-safe arithmetic
    assign wr_hit = (({24'd0, wr_addr} - WR_LO) < NUM_WR);

    for (genvar g = 0; g < NUM_WR; g++) begin : g_ctrl
        localparam logic [7:0] ADDR = 8'(WR_LO + g);
        logic [7:0] q;

        // One control register: load its reset byte, then take matching writes
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= RST_IMAGE[g*8 +: 8];
            end else if (wr_en && wr_addr == ADDR) begin
                q <= wr_data;
            end
        end

        assign ctrl_out[g*8 +: 8] = q;

        AST_INSIDE_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_addr == ADDR) |=> (q == $past(wr_data))); // R3
    end

    // Status read decoder; unlisted addresses read as zero
    always_comb begin
        rd_data = 8'h00;
        if (rd_addr == 8'(RD_SOLO)) begin
            rd_data = stat_in[7:0];
        end
        for (int k = 0; k < int'(NUM_RNG); k++) begin
            if (rd_addr == 8'(RD_LO + k)) begin
                rd_data = stat_in[(k+1)*8 +: 8];
            end
        end
    end

    AST_OUTSIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !wr_hit) |=> (ctrl_out == $past(ctrl_out))); // R4

endmodule

// File: rtl/i2c_regbank_target.sv
// Module i2c_regbank_target
// Top level of the I2C register target. It joins the line synchronizer,
// the byte engine and the register file. SDA is open drain: sda_pull=1
// means the pad must pull the line low.
// Assumes scl_in/sda_in carry the resolved line levels, and that the
// system clock is at least about 16 times the SCL rate.
module i2c_regbank_target
    import i2crb_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned WR_LO       = DEF_WR_LO,
    parameter int unsigned WR_HI       = DEF_WR_HI,
    parameter int unsigned RD_SOLO     = DEF_RD_SOLO,
    parameter int unsigned RD_LO       = DEF_RD_LO,
    parameter int unsigned RD_HI       = DEF_RD_HI,
    parameter logic [8*(WR_HI-WR_LO+1)-1:0] RST_IMAGE = DEF_RST_IMAGE
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          addr_sel,
    input  logic                          scl_in,
    input  logic                          sda_in,
    output logic                          sda_pull,
    input  logic [8*(RD_HI-RD_LO+2)-1:0]  stat_in,
    output logic [8*(WR_HI-WR_LO+1)-1:0]  ctrl_out
);
    logic       scl_lvl;
    logic       sda_lvl;
    logic       scl_rise;
    logic       scl_fall;
    logic       bus_start;
    logic       bus_stop;
    logic [7:0] rd_addr;
    logic [7:0] rd_data;
    logic       wr_en;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;

    i2crb_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_pin   (scl_in),
        .sda_pin   (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2crb_byte_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_sel  (addr_sel),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sda_oe    (sda_pull)
    );

    i2crb_reg_file #(
        .WR_LO     (WR_LO),
        .WR_HI     (WR_HI),
        .RD_SOLO   (RD_SOLO),
        .RD_LO     (RD_LO),
        .RD_HI     (RD_HI),
        .RST_IMAGE (RST_IMAGE)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .stat_in  (stat_in),
        .ctrl_out (ctrl_out)
    );

endmodule

// File: tb/tb_i2c_regbank_target.sv
// Bench for i2c_regbank_target: a table of single-byte transfers walked
// by one loop, then directed cases for reset, bursts, foreign addresses
// and aborted transfers.
module tb_i2c_regbank_target;

    localparam int Q = 10;   // clock cycles per quarter SCL period

    typedef struct packed {
        logic       rd;
        logic [7:0] sub;
        logic [7:0] val;
    } vec_t;

    localparam vec_t VT [10] = '{
        '{1'b0, 8'h00, 8'hA5},
        '{1'b0, 8'h10, 8'hFF},
        '{1'b0, 8'h1F, 8'h3C},
        '{1'b0, 8'h0B, 8'h5A},
        '{1'b1, 8'h28, 8'hE1},
        '{1'b1, 8'h2A, 8'h96},
        '{1'b1, 8'h2C, 8'hC3},
        '{1'b1, 8'h29, 8'h00},
        '{1'b1, 8'h05, 8'h00},
        '{1'b1, 8'h2D, 8'h00}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         addr_sel = 1'b0;
    logic         scl_m = 1'b1;
    logic         sda_m = 1'b1;
    logic         sda_pull;
    logic [31:0]  stat = 32'hC35A96E1;
    logic [271:0] ctrl;
    wire          sda_bus = sda_m & ~sda_pull;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int oe_viol = 0;
    logic prev_oe = 1'b0;

    always #10 clk = ~clk;

    i2c_regbank_target dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_sel (addr_sel),
        .scl_in   (scl_m),
        .sda_in   (sda_bus),
        .sda_pull (sda_pull),
        .stat_in  (stat),
        .ctrl_out (ctrl)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // R11 monitor: the SDA drive may only change while SCL is low
    always @(negedge clk) begin
        if (rst_n && sda_pull !== prev_oe && scl_m) oe_viol++;
        prev_oe = sda_pull;
    end

    function automatic logic [7:0] getc(input int idx);
        return ctrl[idx*8 +: 8];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = b[7-i]; qwait();
            scl_m = 1'b1;   qwait(); qwait();
            scl_m = 1'b0;   qwait();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        ack = ~sda_bus; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            scl_m = 1'b1; qwait();
            b = {b[6:0], sda_bus}; qwait();
            scl_m = 1'b0; qwait(); qwait();
        end
        sda_m = nack; qwait();
        scl_m = 1'b1; qwait(); qwait();
        scl_m = 1'b0; qwait();
        sda_m = 1'b1;
    endtask

    task automatic wr1(input logic [7:0] dev, input logic [7:0] sub, input logic [7:0] val,
                       output logic [2:0] acks);
        bus_start();
        send_byte(dev, acks[2]);
        send_byte(sub, acks[1]);
        send_byte(val, acks[0]);
        bus_stop();
    endtask

    task automatic rd1(input logic [7:0] sub, output logic [7:0] val, output logic [2:0] acks);
        bus_start();
        send_byte(8'hD6, acks[2]);
        send_byte(sub, acks[1]);
        bus_start();
        send_byte(8'hD7, acks[0]);
        recv_byte(1'b1, val);
        bus_stop();
    endtask

    initial begin
        logic [2:0]   acks;
        logic [7:0]   v;
        logic         a;
        logic [271:0] snap;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R10: reset image and released bus
        check("R10 reg00 reset", getc(0), 8'h00);
        check("R10 reg01 reset", getc(1), 8'h40);
        check("R10 reg12 reset", getc('h12), 8'h0F);
        check("R10 reg21 reset", getc('h21), 8'h88);
        check("R10 sda released", sda_pull, 1'b0);

        // Table walk: single-byte writes (R3) and reads (R6, R7)
        for (int i = 0; i < 10; i++) begin
            if (!VT[i].rd) begin
                wr1(8'hD6, VT[i].sub, VT[i].val, acks);
                check("R3 write acks", acks, 3'b111);
                check("R3 write value", getc(int'(VT[i].sub)), VT[i].val);
            end else begin
                rd1(VT[i].sub, v, acks);
                check("R1 read acks", acks, 3'b111);
                if (VT[i].val != 8'h00) check("R6 status read", v, VT[i].val);
                else                   check("R7 zero read", v, 8'h00);
            end
        end

        // R3/R5: burst write at 08h
        bus_start();
        send_byte(8'hD6, acks[0]);
        send_byte(8'h08, acks[1]);
        send_byte(8'h11, acks[2]);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        bus_stop();
        check("R5 burst reg08", getc(8), 8'h11);
        check("R5 burst reg09", getc(9), 8'h22);
        check("R5 burst reg0A", getc('h0A), 8'h33);

        // R4/R5: burst runs across the end of the write window
        bus_start();
        send_byte(8'hD6, a);
        send_byte(8'h20, a);
        send_byte(8'hA1, a);
        send_byte(8'hA2, a);
        send_byte(8'hA3, a);
        bus_stop();
        check("R4 outside byte acked", a, 1'b1);
        check("R5 reg20", getc('h20), 8'hA1);
        check("R5 reg21", getc('h21), 8'hA2);
        check("R4 no wrap into reg00", getc(0), 8'hA5);

        // R4: single write beyond the window changes nothing
        snap = ctrl;
        wr1(8'hD6, 8'h30, 8'h77, acks);
        check("R4 outside acks", acks, 3'b111);
        check("R4 ctrl unchanged", 32'(ctrl != snap), 32'd0);

        // R5/R6/R7: read burst from 28h across the gap at 29h
        bus_start();
        send_byte(8'hD6, a);
        send_byte(8'h28, a);
        bus_start();
        send_byte(8'hD7, a);
        recv_byte(1'b0, v); check("R6 burst 28h", v, 8'hE1);
        recv_byte(1'b0, v); check("R7 burst 29h", v, 8'h00);
        recv_byte(1'b0, v); check("R5 burst 2Ah", v, 8'h96);
        recv_byte(1'b0, v); check("R5 burst 2Bh", v, 8'h5A);
        recv_byte(1'b0, v); check("R5 burst 2Ch", v, 8'hC3);
        recv_byte(1'b1, v); check("R7 burst 2Dh", v, 8'h00);
        bus_stop();

        // R8: NACK at 28h; next byte (29h = 00h) must not be driven
        bus_start();
        send_byte(8'hD6, a);
        send_byte(8'h28, a);
        bus_start();
        send_byte(8'hD7, a);
        recv_byte(1'b1, v);
        qwait();
        check("R8 released after nack", {sda_pull, sda_bus}, 2'b01);
        bus_stop();

        // R2: foreign address (strap bit mismatch) is ignored
        wr1(8'hDE, 8'h03, 8'h99, acks);
        check("R2 no acks", acks, 3'b000);
        check("R2 reg03 untouched", getc(3), 8'h00);

        // R1: strap set to 1 selects DEh, D6h becomes foreign
        addr_sel = 1'b1;
        qwait();
        wr1(8'hDE, 8'h15, 8'h5E, acks);
        check("R1 strap=1 acks", acks, 3'b111);
        check("R1 strap=1 reg15", getc('h15), 8'h5E);
        wr1(8'hD6, 8'h15, 8'h00, acks);
        check("R2 old address nacked", acks, 3'b000);
        check("R2 reg15 kept", getc('h15), 8'h5E);
        addr_sel = 1'b0;
        qwait();

        // R9: stop in the middle of a data byte
        bus_start();
        send_byte(8'hD6, a);
        send_byte(8'h05, a);
        send_bits(8'hFF, 4);
        bus_stop();
        check("R9 stop mid-byte, reg05", getc(5), 8'h00);

        // R9: repeated start in the middle of a data byte
        bus_start();
        send_byte(8'hD6, a);
        send_byte(8'h06, a);
        send_bits(8'hFF, 3);
        bus_start();
        send_byte(8'hD6, acks[0]);
        send_byte(8'h07, acks[1]);
        send_byte(8'h3C, acks[2]);
        bus_stop();
        check("R9 start mid-byte acks", acks, 3'b111);
        check("R9 aborted reg06", getc(6), 8'h00);
        check("R9 restarted reg07", getc(7), 8'h3C);

        // R11: drive changes seen only while SCL low
        check("R11 sda changes with scl high", oe_viol, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule